// File: doc/BRIEF.md
# Shared-Alphabet Sign-Magnitude Multiplier

This block multiplies a signed two's-complement operand by a 17-bit coefficient held in sign-magnitude form, without a partial-product array. A precompute stage forms the operand times each of the eight odd constants 1, 3, 5, 7, 9, 11, 13 and 15 (the "alphabet"). The 16-bit coefficient magnitude is cut into four 4-bit digits. For each digit, a select unit strips trailing zeros to reach an odd value, uses that value to pick one precomputed product through an 8:1 mux, and shifts the product back left by the number of zeros it stripped. A digit of zero is gated to a zero contribution.

A final adder aligns the four select-unit outputs at weights 1, 16, 256 and 4096 and sums them. When the coefficient sign bit is set, the sum is bit-inverted and the sign bit enters as a carry-in, which negates it. The product is registered once, so it appears on the output one clock after the operands are presented. The alphabet products are also driven out combinationally, so that further select-and-add units elsewhere can share one precompute stage.

Top module: `csm_mult`

## Requirements
- R1: With the coefficient sign bit (bit 16) at 0, `prod_out` equals the signed operand times the unsigned magnitude `coef_in[15:0]`, one clock after the operands are presented.
- R2: `alpha_out` lane k (bits `k*20 +: 20`, k = 0..7) equals, combinationally, the sign-extended operand times 2k+1.
- R3: A coefficient digit of 0000 contributes nothing to the product: a coefficient whose nonzero digits are interleaved with zero digits gives the same product as the arithmetic value of the whole magnitude.
- R4: Each nonzero digit value 1 to 15 in the lowest digit gives the operand times that value, including the even values that need a shift of 1 to 3 bits.
- R5: A magnitude of zero gives a product of exactly zero, whether the sign bit is 0 or 1.
- R6: With the sign bit at 1, `prod_out` is the two's-complement negation of the product the same magnitude gives with the sign bit at 0.
- R7: While `rst_n` is low, `prod_out` is zero.
- R8: At the range extremes (operand -32768 or 32767, magnitude 0xFFFF, either sign) the 33-bit product is exact, without overflow.
- R9: A nonzero digit in digit position d (bits `4d+3:4d`) is weighted by 16^d.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the product register updates on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the product register |
| x_in | input | 16 | Signed two's-complement operand |
| coef_in | input | 17 | Coefficient: bit 16 sign, bits 15:0 magnitude |
| alpha_out | output | 160 | Eight 20-bit signed alphabet products, lane k holds operand times 2k+1 |
| prod_out | output | 33 | Registered signed product |

## Verification
The assertions assume that `x_in` and `coef_in` carry known values at every rising edge after reset is released, and that each pair is held for the whole cycle in which it is sampled; the bench changes both only on falling edges and drives them from time zero. They also assume the one-cycle product latency, which the bench's scoreboard mirrors by queuing each expected product as it drives the operands and popping it just after the next rising edge. The stimulus covers every digit value, every digit position, zero digits mixed among nonzero ones, both signs of a zero magnitude and the signed extremes, plus a run of random pairs.

// File: rtl/csm_pkg.sv
package csm_pkg;
    // Coefficient digit width handled by one select unit.
    localparam int DIGIT_W = 4;
    // Number of odd alphabet constants needed to cover every nonzero digit.
    localparam int N_ALPHA = 1 << (DIGIT_W - 1);
    // Width of the shift count a select unit records.
    localparam int SHIFT_W = $clog2(DIGIT_W);
endpackage

// File: rtl/csm_precompute.sv
module csm_precompute
    import csm_pkg::*;
#(
    parameter int XW = 16,
    parameter int AW = XW + DIGIT_W
) (
    input  logic signed [XW-1:0]        x_in,
    output logic        [N_ALPHA*AW-1:0] alpha_bus
);
    logic signed [AW-1:0] x_wide;
    assign x_wide = AW'(x_in);

    // Each lane is the operand times one odd constant, built from shifts and adds.
    for (genvar k = 0; k < N_ALPHA; k++) begin : g_lane
        localparam logic [DIGIT_W-1:0] ODD_C = DIGIT_W'(2 * k + 1);
        logic signed [AW-1:0] acc;
        always_comb begin
            acc = '0;
            for (int b = 0; b < DIGIT_W; b++) begin
                if (ODD_C[b]) acc = acc + (x_wide <<< b);
            end
        end
        assign alpha_bus[k*AW +: AW] = acc;
    end
endmodule

// File: rtl/csm_select_unit.sv
module csm_select_unit
    import csm_pkg::*;
#(
    parameter int AW = 20,
    parameter int PW = 33
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [DIGIT_W-1:0]      digit,
    input  logic [N_ALPHA*AW-1:0]   alpha_bus,
    output logic signed [PW-1:0]    part
);
    logic [SHIFT_W-1:0]    shamt;
    logic                  found;
    logic [DIGIT_W-1:0]    odd_val;
    logic [DIGIT_W-2:0]    sel_idx;
    logic signed [AW-1:0]  picked;
    logic signed [PW-1:0]  picked_ext;
    logic signed [PW-1:0]  restored;
    logic                  nonzero;

    // Normaliser: count trailing zeros up to the first set bit.
    always_comb begin
        shamt = '0;
        found = 1'b0;
        for (int b = 0; b < DIGIT_W; b++) begin
            if (!found && digit[b]) begin
                shamt = SHIFT_W'(b);
                found = 1'b1;
            end
        end
    end

    assign odd_val = digit >> shamt;
    assign sel_idx = (DIGIT_W-1)'(odd_val >> 1);

    // 8:1 selection of the shared alphabet product.
    assign picked     = alpha_bus[sel_idx*AW +: AW];
    assign picked_ext = PW'(picked);

    // Inverse shift restores the stripped power of two.
    assign restored = picked_ext <<< shamt;

    // A zero digit has no odd form; gate its contribution off.
    assign nonzero = |digit;
    assign part    = restored & {PW{nonzero}};

    logic signed [PW-1:0] unit_ref;
    logic signed [PW-1:0] digit_ext;
    assign unit_ref  = PW'($signed(alpha_bus[AW-1:0]));
    assign digit_ext = PW'(digit);

    assert_zero_digit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (digit == '0) |-> (part == '0));

    assert_digit_product_R4: assert property (@(posedge clk) disable iff (!rst_n)
        part == unit_ref * digit_ext);
endmodule

// File: rtl/csm_final_adder.sv
module csm_final_adder
    import csm_pkg::*;
#(
    parameter int PW = 33,
    parameter int ND = 4
) (
    input  logic                 neg,
    input  logic [ND*PW-1:0]     parts,
    output logic signed [PW-1:0] sum
);
    logic signed [PW-1:0] total;

    // Align each digit contribution at its power-of-sixteen weight.
    always_comb begin
        total = '0;
        for (int j = 0; j < ND; j++) begin
            total = total + ($signed(parts[j*PW +: PW]) <<< (j * DIGIT_W));
        end
    end

    // Conditional negation: invert and inject the sign as the carry-in.
    assign sum = (total ^ {PW{neg}}) + PW'(neg);
endmodule

// File: rtl/csm_mult.sv
module csm_mult
    import csm_pkg::*;
#(
    parameter int XW = 16,
    parameter int CW = 17
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic signed [XW-1:0]               x_in,
    input  logic        [CW-1:0]               coef_in,
    output logic        [N_ALPHA*(XW+DIGIT_W)-1:0] alpha_out,
    output logic signed [XW+CW-1:0]            prod_out
);
    localparam int AW = XW + DIGIT_W;
    localparam int PW = XW + CW;
    localparam int MW = CW - 1;
    localparam int ND = MW / DIGIT_W;

    logic [ND*PW-1:0]     parts;
    logic signed [PW-1:0] prod_d;

    csm_precompute #(.XW(XW), .AW(AW)) u_pre (
        .x_in      (x_in),
        .alpha_bus (alpha_out)
    );

    for (genvar d = 0; d < ND; d++) begin : g_sel
        logic signed [PW-1:0] part_d;
        csm_select_unit #(.AW(AW), .PW(PW)) u_sel (
            .clk       (clk),
            .rst_n     (rst_n),
            .digit     (coef_in[d*DIGIT_W +: DIGIT_W]),
            .alpha_bus (alpha_out),
            .part      (part_d)
        );
        assign parts[d*PW +: PW] = part_d;
    end

    csm_final_adder #(.PW(PW), .ND(ND)) u_add (
        .neg   (coef_in[MW]),
        .parts (parts),
        .sum   (prod_d)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prod_out <= '0;
        else        prod_out <= prod_d;
    end

    // Reference terms for the checks below.
    logic signed [PW-1:0] x_ext;
    logic signed [PW-1:0] mag_ext;
    logic signed [AW-1:0] x_alpha;
    assign x_ext   = PW'(x_in);
    assign mag_ext = PW'(coef_in[MW-1:0]);
    assign x_alpha = AW'(x_in);

    assert_positive_product_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !coef_in[MW] |=> prod_out == $past(x_ext) * $past(mag_ext));

    assert_negated_product_R6: assert property (@(posedge clk) disable iff (!rst_n)
        coef_in[MW] |=> prod_out == -($past(x_ext) * $past(mag_ext)));

    assert_zero_magnitude_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (coef_in[MW-1:0] == '0) |=> (prod_out == '0));

    assert_reset_clear_R7: assert property (@(posedge clk)
        !rst_n |=> (prod_out == '0));

    for (genvar k = 0; k < N_ALPHA; k++) begin : g_alpha_chk
        assert_alpha_lane_R2: assert property (@(posedge clk) disable iff (!rst_n)
            $signed(alpha_out[k*AW +: AW]) == x_alpha * AW'(2 * k + 1));
    end
endmodule

// File: tb/csm_mult_tb_top.sv
module csm_mult_tb_top;
    localparam int XW = 16;
    localparam int CW = 17;
    localparam int AW = XW + 4;
    localparam int PW = XW + CW;

    logic                   clk = 1'b0;
    logic                   rst_n = 1'b0;
    logic signed [XW-1:0]   x_in = 16'sd100;
    logic        [CW-1:0]   coef_in = 17'd5;
    logic        [8*AW-1:0] alpha_out;
    logic signed [PW-1:0]   prod_out;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    longint exp_q[$];
    string  tag_q[$];

    always #2 clk = ~clk;

    csm_mult #(.XW(XW), .CW(CW)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .x_in      (x_in),
        .coef_in   (coef_in),
        .alpha_out (alpha_out),
        .prod_out  (prod_out)
    );

    function automatic longint model(input longint x, input logic [CW-1:0] c);
        longint m;
        m = longint'(c[CW-2:0]);
        return c[CW-1] ? -(x * m) : x * m;
    endfunction

    task automatic check(input string tag, input longint act, input longint expv);
        checks++;
        if (act != expv) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    // Driver: present operands on a falling edge and queue the expected product.
    task automatic drive(input longint x, input logic [CW-1:0] c, input string tag);
        @(negedge clk);
        x_in    = XW'(x);
        coef_in = c;
        exp_q.push_back(model(x, c));
        tag_q.push_back(tag);
    endtask

    // Combinational check of the shared alphabet lanes (R2).
    task automatic check_alpha(input longint x);
        @(negedge clk);
        x_in = XW'(x);
        #1;
        for (int k = 0; k < 8; k++) begin
            check("R2 alpha lane", longint'($signed(alpha_out[k*AW +: AW])), x * (2 * k + 1));
        end
    endtask

    // Monitor: the product registers on the rising edge; compare just after it.
    always @(posedge clk) begin
        #1;
        if (exp_q.size() > 0) begin
            check(tag_q.pop_front(), longint'(prod_out), exp_q.pop_front());
        end
    end

    initial begin
        #1;
        check("R7 reset value", longint'(prod_out), 0);
        repeat (3) @(posedge clk);
        #1;
        check("R7 held in reset", longint'(prod_out), 0);
        @(negedge clk);
        rst_n = 1'b1;

        check_alpha(1234);
        check_alpha(-32768);
        check_alpha(32767);
        check_alpha(-7);

        // R5: zero magnitude with both signs
        drive(-12345, 17'h00000, "R5 zero mag positive");
        drive(-12345, 17'h10000, "R5 zero mag negative");
        drive(32767, 17'h10000, "R5 zero mag negative max x");

        // R4: every digit value in the lowest digit
        for (int v = 1; v < 16; v++) drive(-3001, 17'(v), "R4 digit value");
        for (int v = 1; v < 16; v++) drive(777, 17'(v), "R4 digit value");

        // R9: single nonzero digit in each position
        drive(1000, 17'h0000C, "R9 digit0 weight");
        drive(1000, 17'h000A0, "R9 digit1 weight");
        drive(1000, 17'h00E00, "R9 digit2 weight");
        drive(1000, 17'h08000, "R9 digit3 weight");
        drive(-5, 17'h01000, "R9 digit3 weight neg x");

        // R3: zero digits interleaved with nonzero ones
        drive(4321, 17'h00F0F, "R3 zero digits");
        drive(-4321, 17'h0A005, "R3 zero digits");
        drive(999, 17'h00300, "R3 zero digits");

        // R6: same magnitude, both signs
        drive(1234, 17'h01234, "R6 positive ref");
        drive(1234, 17'h11234, "R6 negated");
        drive(-1234, 17'h1BEEF, "R6 negated neg x");

        // R8: range extremes
        drive(-32768, 17'h0FFFF, "R8 min x max mag");
        drive(-32768, 17'h1FFFF, "R8 min x max mag neg");
        drive(32767, 17'h0FFFF, "R8 max x max mag");
        drive(32767, 17'h1FFFF, "R8 max x max mag neg");

        // R1: random operand pairs
        for (int i = 0; i < 60; i++) begin
            logic [31:0] r;
            r = $urandom;
            drive(longint'($signed(r[15:0])), 17'($urandom), "R1 random");
        end

        repeat (3) @(posedge clk);
        #2;
        done = 1'b1;
    end

    initial begin
        fork
            begin
                wait (done);
            end
            begin
                repeat (20000) @(posedge clk);
                checks++;
                failures++;
                $display("FAIL watchdog actual=timeout expected=completion");
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule